// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block sits between a host port and two on-chip arrays: a working SRAM and a shadow array that models nonvolatile cells. No command pins exist. The host starts a STORE or a RECALL by issuing a fixed series of six read cycles. The first five addresses are the same for both operations. The sixth address picks the operation: a STORE copies every SRAM word into the shadow array, and a RECALL clears the SRAM and then loads it from the shadow array.

While an operation runs, the controller raises `busy` and ignores every host access. The STORE and RECALL durations are set by parameters, counted in clock cycles. A low-voltage flag suppresses SRAM writes and software STORE requests, but it does not block RECALL. The reads that make up a sequence return normal SRAM data, so the detection has no effect on the data path. Each clock cycle in which `ce_n` is low counts as one host access. `addr` is 13 bits wide, and the array is indexed by its low log2(MEM_DEPTH) bits.

Top module: `nvsram_ctl`

## Requirements
- R1: After reset, `busy` is 0 and `rdata` is 0. Every SRAM word resets to 0. Shadow word i resets to (37*i + 5) mod 256.
- R2: A cycle with `ce_n`=0 and `we_n`=0 writes `wdata` into SRAM word `addr` mod MEM_DEPTH. A cycle with `ce_n`=1 changes nothing.
- R3: A read cycle (`ce_n`=0, `we_n`=1) updates `rdata` on the next clock edge. `rdata` takes the addressed word when `oe_n`=0 and takes 0 when `oe_n`=1.
- R4: The STORE sequence is six consecutive read cycles at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F. It raises `busy` from the next cycle for exactly STORE_CYCLES cycles and copies the SRAM into the shadow array.
- R5: The same five reads followed by a read of 0x0F0E start a RECALL. `busy` is high for exactly RECALL_CYCLES cycles. The SRAM is cleared and then loaded from the shadow array. The shadow array is left unchanged, so a RECALL can be repeated any number of times.
- R6: A write cycle, or a read at an address that is out of order, returns the matcher to idle. If that read is at 0x0000, it counts as the first step of a new sequence.
- R7: A read counts as a sequence step whatever the level of `oe_n`. Sequence reads return SRAM data as in R3.
- R8: While `busy` is high, writes do not change the SRAM, reads leave `rdata` unchanged, and no sequence step is taken.
- R9: While `lowv` is 1, writes are dropped, and a STORE sixth read starts nothing and returns the matcher to idle. A RECALL sequence still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; one access per cycle while low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; gates read data only |
| addr | input | 13 | Access address |
| wdata | input | DATA_W | Write data |
| lowv | input | 1 | Low-voltage flag |
| rdata | output | DATA_W | Registered read data |
| busy | output | 1 | High while a STORE or RECALL runs |

## Verification
The assertions check on every cycle that `busy` starts only right after an accepted read at one of the two final addresses. They also check that a low-voltage start is always a RECALL, that `rdata` stays frozen during a busy interval, that a read with the output disabled returns zero, and that no busy interval outlasts the longer duration. Only the bench scenarios can show the effects on memory contents: the exact busy lengths, the shadow reset pattern appearing after a RECALL, the data a STORE keeps, writes dropped under low voltage or during busy, and the matcher restart after a broken sequence.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  localparam int ADDR_W = 13;

  localparam logic [ADDR_W-1:0] KEY_A0     = 13'h0000;
  localparam logic [ADDR_W-1:0] KEY_A1     = 13'h1555;
  localparam logic [ADDR_W-1:0] KEY_A2     = 13'h0AAA;
  localparam logic [ADDR_W-1:0] KEY_A3     = 13'h1FFF;
  localparam logic [ADDR_W-1:0] KEY_A4     = 13'h10F0;
  localparam logic [ADDR_W-1:0] KEY_STORE  = 13'h0F0F;
  localparam logic [ADDR_W-1:0] KEY_RECALL = 13'h0F0E;

  // expected address for prefix step 0..4
  function automatic logic [ADDR_W-1:0] key_addr(input logic [2:0] step);
    case (step)
      3'd0:    key_addr = KEY_A0;
      3'd1:    key_addr = KEY_A1;
      3'd2:    key_addr = KEY_A2;
      3'd3:    key_addr = KEY_A3;
      default: key_addr = KEY_A4;
    endcase
  endfunction

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_STORE,
    OP_RCL_CLR,
    OP_RCL_LOAD
  } op_state_e;

endpackage

// File: rtl/nvs_rst_sync.sv
module nvs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/nvs_seq_match.sv
module nvs_seq_match
  import nvsram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cyc,
  input  logic              wr_cyc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lowv,
  output logic              store_req,
  output logic              recall_req
);

  logic [2:0] step_q, step_d;

  always_comb begin
    step_d     = step_q;
    store_req  = 1'b0;
    recall_req = 1'b0;
    if (wr_cyc) begin
      step_d = 3'd0;
    end else if (rd_cyc) begin
      if (step_q == 3'd5) begin
        if (addr == KEY_STORE && !lowv) store_req  = 1'b1;
        if (addr == KEY_RECALL)         recall_req = 1'b1;
        step_d = (addr == KEY_A0) ? 3'd1 : 3'd0;
      end else if (addr == key_addr(step_q)) begin
        step_d = step_q + 3'd1;
      end else if (addr == KEY_A0) begin
        step_d = 3'd1;
      end else begin
        step_d = 3'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 3'd0;
    else        step_q <= step_d;
  end

endmodule

// File: rtl/nvs_op_timer.sv
module nvs_op_timer
  import nvsram_pkg::*;
#(
  parameter int STORE_CYCLES  = 200,
  parameter int RECALL_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic store_req,
  input  logic recall_req,
  output logic busy,
  output logic do_store,
  output logic do_clear,
  output logic do_load
);

  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  op_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    do_store = 1'b0;
    do_clear = 1'b0;
    do_load  = 1'b0;
    case (st_q)
      OP_IDLE: begin
        if (store_req) begin
          st_d  = OP_STORE;
          cnt_d = CNT_W'(STORE_CYCLES - 1);
        end else if (recall_req) begin
          st_d = OP_RCL_CLR;
        end
      end
      OP_STORE: begin
        if (cnt_q == '0) begin
          do_store = 1'b1;
          st_d     = OP_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      OP_RCL_CLR: begin
        do_clear = 1'b1;
        st_d     = OP_RCL_LOAD;
        cnt_d    = CNT_W'(RECALL_CYCLES - 2);
      end
      default: begin
        if (cnt_q == '0) begin
          do_load = 1'b1;
          st_d    = OP_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OP_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q != OP_IDLE);

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
  parameter int DATA_W    = 8,
  parameter int MEM_DEPTH = 64,
  localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              do_store,
  input  logic              do_clear,
  input  logic              do_load,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] sram_q   [MEM_DEPTH];
  logic [DATA_W-1:0] shadow_q [MEM_DEPTH];

  for (genvar g = 0; g < MEM_DEPTH; g++) begin : g_word
    logic sel_wr;
    assign sel_wr = wr_en && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sram_q[g] <= '0;
      else if (do_clear) sram_q[g] <= '0;
      else if (do_load)  sram_q[g] <= shadow_q[g];
      else if (sel_wr)   sram_q[g] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shadow_q[g] <= DATA_W'(37 * g + 5);
      else if (do_store) shadow_q[g] <= sram_q[g];
    end
  end

  assign rd_word = sram_q[idx];

endmodule

// File: rtl/nvsram_ctl.sv
module nvsram_ctl
  import nvsram_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int MEM_DEPTH     = 64,
  parameter int STORE_CYCLES  = 200,
  parameter int RECALL_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lowv,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);

  localparam int IDX_W = $clog2(MEM_DEPTH);

  logic              rst_s_n;
  logic              rd_cyc, wr_cyc, wr_en;
  logic              store_req, recall_req;
  logic              do_store, do_clear, do_load;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;

  nvs_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign rd_cyc = !busy && !ce_n &&  we_n;
  assign wr_cyc = !busy && !ce_n && !we_n;
  assign wr_en  = wr_cyc && !lowv;

  nvs_seq_match u_match (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .rd_cyc     (rd_cyc),
    .wr_cyc     (wr_cyc),
    .addr       (addr),
    .lowv       (lowv),
    .store_req  (store_req),
    .recall_req (recall_req)
  );

  nvs_op_timer #(
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .store_req  (store_req),
    .recall_req (recall_req),
    .busy       (busy),
    .do_store   (do_store),
    .do_clear   (do_clear),
    .do_load    (do_load)
  );

  nvs_arrays #(
    .DATA_W    (DATA_W),
    .MEM_DEPTH (MEM_DEPTH)
  ) u_arrays (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_en    (wr_en),
    .idx      (addr[IDX_W-1:0]),
    .wdata    (wdata),
    .do_store (do_store),
    .do_clear (do_clear),
    .do_load  (do_load),
    .rd_word  (rd_word)
  );

  assign rdata_en = rd_cyc;
  assign rdata_d  = oe_n ? '0 : rd_word;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/nvsram_ctl_chk.sv
module nvsram_ctl_chk
  import nvsram_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int STORE_CYCLES  = 200,
  parameter int RECALL_CYCLES = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic              lowv,
  input logic [DATA_W-1:0] rdata,
  input logic              busy
);

  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  AST_START_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!ce_n && we_n)); // R7

  AST_START_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(addr) == KEY_STORE || $past(addr) == KEY_RECALL)); // R4

  AST_LOWV_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(lowv)) |-> $past(addr) == KEY_RECALL); // R9

  AST_RDATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(rdata)); // R8

  AST_OE_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy && !ce_n && we_n && oe_n) |-> rdata == '0); // R3

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < MAX_CYC); // R5

endmodule

bind nvsram_ctl nvsram_ctl_chk #(
  .DATA_W        (DATA_W),
  .STORE_CYCLES  (STORE_CYCLES),
  .RECALL_CYCLES (RECALL_CYCLES)
) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .ce_n  (ce_n),
  .we_n  (we_n),
  .oe_n  (oe_n),
  .addr  (addr),
  .lowv  (lowv),
  .rdata (rdata),
  .busy  (busy)
);

// File: tb/nvsram_ctl_tb_top.sv
module nvsram_ctl_tb_top;

  localparam int DW = 8;
  localparam int ST = 6;
  localparam int RC = 5;

  typedef struct packed {
    logic        ce_n;
    logic        we_n;
    logic        oe_n;
    logic        lowv;
    logic [12:0] addr;
    logic [7:0]  wdata;
    logic        chk;
    logic [7:0]  exp_rd;
    logic        exp_busy;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,13'h0005,8'h11,1'b0,8'h00,1'b0}, // R2 write
    '{1'b0,1'b0,1'b1,1'b0,13'h0007,8'h22,1'b0,8'h00,1'b0}, // R2 write
    '{1'b0,1'b1,1'b0,1'b0,13'h0005,8'h00,1'b1,8'h11,1'b0}, // R3 read
    '{1'b0,1'b1,1'b1,1'b0,13'h0007,8'h00,1'b1,8'h00,1'b0}, // R3 oe off
    '{1'b0,1'b0,1'b1,1'b1,13'h0005,8'h99,1'b0,8'h00,1'b0}, // R9 lowv write
    '{1'b0,1'b1,1'b0,1'b0,13'h0005,8'h00,1'b1,8'h11,1'b0}, // R9
    '{1'b1,1'b0,1'b1,1'b0,13'h0007,8'h55,1'b0,8'h00,1'b0}, // R2 deselected
    '{1'b0,1'b1,1'b0,1'b0,13'h0007,8'h00,1'b1,8'h22,1'b0}, // R2
    '{1'b0,1'b1,1'b0,1'b0,13'h0000,8'h00,1'b1,8'h05,1'b0}, // R7 data
    '{1'b0,1'b1,1'b1,1'b0,13'h1555,8'h00,1'b0,8'h00,1'b0}, // R7 oe off
    '{1'b0,1'b1,1'b0,1'b0,13'h0AAA,8'h00,1'b0,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,13'h1FFF,8'h00,1'b0,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,13'h10F0,8'h00,1'b0,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,13'h0F0F,8'h00,1'b0,8'h00,1'b1}, // R4 start
    '{1'b0,1'b0,1'b1,1'b0,13'h0005,8'hEE,1'b0,8'h00,1'b1}, // R8 write
    '{1'b1,1'b1,1'b1,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b0}, // R4 length
    '{1'b0,1'b1,1'b0,1'b0,13'h0005,8'h00,1'b1,8'h11,1'b0}, // R8
    '{1'b0,1'b0,1'b1,1'b0,13'h0005,8'h33,1'b0,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,13'h0005,8'h00,1'b1,8'h33,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,13'h1555,8'h00,1'b0,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,13'h0AAA,8'h00,1'b0,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,13'h1FFF,8'h00,1'b0,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,13'h10F0,8'h00,1'b0,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,13'h0F0E,8'h00,1'b0,8'h00,1'b1}, // R5 start
    '{1'b1,1'b1,1'b1,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,13'h0000,8'h00,1'b0,8'h00,1'b0}, // R5 length
    '{1'b0,1'b1,1'b0,1'b0,13'h0005,8'h00,1'b1,8'h11,1'b0}, // R5 restored
    '{1'b0,1'b1,1'b0,1'b0,13'h0007,8'h00,1'b1,8'h22,1'b0}  // R5 restored
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, we_n, oe_n, lowv;
  logic [12:0]   addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  nvsram_ctl #(
    .DATA_W        (DW),
    .MEM_DEPTH     (64),
    .STORE_CYCLES  (ST),
    .RECALL_CYCLES (RC)
  ) dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (ce_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .addr  (addr),
    .wdata (wdata),
    .lowv  (lowv),
    .rdata (rdata),
    .busy  (busy)
  );

  function automatic logic [7:0] pat(input int i);
    pat = 8'((37 * i + 5) % 256);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic cyc(input logic c, input logic w, input logic o, input logic lv,
                     input logic [12:0] a, input logic [7:0] d);
    ce_n = c; we_n = w; oe_n = o; lowv = lv; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 13'h0, 8'h0);
  endtask

  task automatic rd(input logic [12:0] a, input logic lv);
    cyc(1'b0, 1'b1, 1'b0, lv, a, 8'h0);
  endtask

  task automatic key_seq(input logic [12:0] last, input logic lv);
    rd(13'h0000, lv);
    rd(13'h1555, lv);
    rd(13'h0AAA, lv);
    rd(13'h1FFF, lv);
    rd(13'h10F0, lv);
    rd(last, lv);
  endtask

  task automatic wait_idle(input int n0, input int exp, input string tag);
    int n = n0;
    while (busy) begin
      idle();
      if (busy) n++;
    end
    check(tag, n, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lowv = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 busy after reset", busy, 0);
    check("R1 rdata after reset", rdata, 0);
    rd(13'h0009, 1'b0);
    check("R1 sram zero", rdata, 0);

    // R1/R5 recall exposes shadow reset pattern
    key_seq(13'h0F0E, 1'b0);
    check("R5 busy start", busy, 1);
    wait_idle(1, RC, "R5 recall length");
    rd(13'h000E, 1'b0); check("R1 shadow pattern 14", rdata, pat(14));
    rd(13'h003F, 1'b0); check("R1 shadow pattern 63", rdata, pat(63));
    rd(13'h0000, 1'b0); check("R1 shadow pattern 0",  rdata, pat(0));

    // vector table
    for (int i = 0; i < NV; i++) begin
      cyc(VT[i].ce_n, VT[i].we_n, VT[i].oe_n, VT[i].lowv, VT[i].addr, VT[i].wdata);
      check($sformatf("vec %0d busy R4/R5/R8", i), busy, VT[i].exp_busy);
      if (VT[i].chk)
        check($sformatf("vec %0d rdata R2/R3/R7", i), rdata, VT[i].exp_rd);
    end

    // R6 write breaks the sequence
    rd(13'h0000, 1'b0); rd(13'h1555, 1'b0); rd(13'h0AAA, 1'b0); rd(13'h1FFF, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 13'h0003, 8'h44);
    rd(13'h10F0, 1'b0); rd(13'h0F0F, 1'b0);
    check("R6 write aborts", busy, 0);
    rd(13'h0003, 1'b0);
    check("R6 write landed", rdata, 8'h44);

    // R6 restart at step one, then R8 read ignored while busy
    rd(13'h0000, 1'b0); rd(13'h1555, 1'b0);
    key_seq(13'h0F0F, 1'b0);
    check("R6 restart store", busy, 1);
    check("R4 sixth read data", rdata, pat(15));
    rd(13'h0003, 1'b0);
    check("R8 read ignored busy", rdata, pat(15));
    wait_idle(2, ST, "R4 store length");

    // R9 store inhibited under low voltage
    key_seq(13'h0F0F, 1'b1);
    check("R9 lowv store blocked", busy, 0);
    rd(13'h0F0F, 1'b0);
    check("R9 matcher idle", busy, 0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 13'h0005, 8'h77);
    rd(13'h0005, 1'b0);
    check("R2 overwrite", rdata, 8'h77);

    // R9 recall under low voltage; R5 shadow unchanged by prior recall
    key_seq(13'h0F0E, 1'b1);
    check("R9 lowv recall runs", busy, 1);
    wait_idle(1, RC, "R5 recall length 2");
    rd(13'h0005, 1'b0); check("R5 repeat recall 5", rdata, 8'h11);
    rd(13'h0003, 1'b0); check("R4 stored value 3", rdata, 8'h44);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule